// File: doc/BRIEF.md
# Graded Inverter Protection Supervisor

This block is the central protection supervisor of a power inverter. Upstream comparators and filters deliver already-qualified fault flags: short circuit, driver undervoltage lockout, severe overcurrent, three graded overvoltage levels, a DC-link undervoltage flag with a fast-collapse qualifier, two overtemperature levels and a sensor-implausible flag. The supervisor merges these flags into one protection state and one action code. Downstream gate-drive logic and the derating path act on that state and action.

Response is graded by severity. Destructive events jump straight to shutdown. Controllable stress climbs from alarm to derate to shutdown. Implausible sensor data only derates. After a shutdown, a saturating repeat counter chooses between an automatic retry through a recovery-check state and a latch that waits for a manual clear. Every state change produces a one-cycle event together with the previous state, the fault code and the action taken, so each trip can be reconstructed later.

Top module: `prot_supervisor`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) state_o is NORMAL (0). prev_state_o, fault_code_o, action_o and repeat_cnt_o are 0, and evt_o, derate_o and shutdown_o are low.
- R2: State codes are NORMAL=0, ALARM=1, DERATE=2, SHUTDOWN=3, LATCH=4 and RESET=5. A short circuit (fault code 1), driver UVLO (code 2) or severe overcurrent (code 4) seen in NORMAL, ALARM, DERATE or RESET moves the block to SHUTDOWN at the next clock edge. shutdown_o is high in SHUTDOWN, LATCH and RESET, and derate_o is high only in DERATE.
- R3: ov_lvl is graded. Bit 0 (level 1, code 10) alone gives ALARM with action LOG (1). Bit 1 (level 2, code 8) gives DERATE with action DERATE (2). Bit 2 (level 3, code 3) gives SHUTDOWN.
- R4: When several flags are active at once, the reported code follows a fixed priority, highest first: short 1, UVLO 2, OV level 3 (3), overcurrent 4, critical overtemperature 5, fast undervoltage 6, overtemperature warning 7, OV level 2 (8), sensor implausible 9, OV level 1 (10), slow undervoltage 11.
- R5: DERATE is left downward only after DWELL_CYCLES consecutive clock edges with no derate-class cause (codes 7, 8, 9). Any such cause restarts the count. On exit the state becomes ALARM if an alarm-class cause remains, otherwise NORMAL. Critical overtemperature in DERATE goes to SHUTDOWN at the next edge.
- R6: The sensor-implausible flag (code 9) puts the block in DERATE and never raises shutdown_o by itself.
- R7: uv_low alone gives ALARM with code 11. uv_low together with uv_fast gives SHUTDOWN with code 6. uv_fast without uv_low is ignored.
- R8: Action codes: on entry to SHUTDOWN, UVLO gives HARD_OFF (4) and every other cause gives SOFT_OFF (3). Entry to LATCH gives HOLD (5), entry to RESET gives CHECK (6) and a return to NORMAL gives RESUME (7).
- R9: repeat_cnt_o increments on each entry into SHUTDOWN. It saturates at RETRY_LIMIT and is cleared only by a manual clear that leaves LATCH.
- R10: At the first edge in SHUTDOWN, the block moves to LATCH if the cause is a short circuit or the repeat count equals RETRY_LIMIT. Otherwise it stays in SHUTDOWN while any trip-class cause (codes 1 to 6) is active, then moves to RESET.
- R11: LATCH keeps shutdown_o high. The block leaves LATCH, for RESET, only when clr_manual is high and no fault flag is active. clr_manual has no effect in any other state.
- R12: In RESET, a trip-class cause returns the block to SHUTDOWN, and the return counts as a repeat. With no fault flag active, the block moves to NORMAL. Otherwise it waits in RESET.
- R13: On every state change evt_o is high for exactly one cycle, with prev_state_o showing the state that was left. fault_code_o carries the top active code, except that entry to LATCH keeps the code that caused the shutdown. These fields hold until the next change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_short | input | 1 | Qualified short-circuit flag |
| flt_uvlo | input | 1 | Gate-driver supply undervoltage lockout |
| flt_ocur | input | 1 | Severe overcurrent flag |
| ov_lvl | input | 3 | DC-link overvoltage levels, bit 0 = level 1 .. bit 2 = level 3 |
| uv_low | input | 1 | DC-link undervoltage flag |
| uv_fast | input | 1 | DC-link voltage falling fast (collapse qualifier) |
| ot_warn | input | 1 | Overtemperature derate threshold crossed |
| ot_crit | input | 1 | Overtemperature hard limit crossed |
| sens_bad | input | 1 | Measurement implausible |
| clr_manual | input | 1 | Manual clear request for LATCH |
| state_o | output | 3 | Current protection state |
| prev_state_o | output | 3 | State left at the last change |
| fault_code_o | output | 4 | Fault code recorded at the last change |
| action_o | output | 3 | Action taken at the last change |
| evt_o | output | 1 | One-cycle pulse after each state change |
| derate_o | output | 1 | Stress-reduction request |
| shutdown_o | output | 1 | Switching disabled |
| repeat_cnt_o | output | $clog2(RETRY_LIMIT+1) | Saturating shutdown repeat count |

## Verification
The hardest situation to reach is the latch caused by accumulated repeats rather than by a severe fault. To get there, the count has to survive several complete shutdown, recovery-check and normal round trips without a reset in between. The stimulus pulses critical overtemperature three times and walks each trip back through RESET to NORMAL. On the third entry it checks that the block latches even though the cause has already cleared. A similar trap is the derate dwell restart: the bench drops the cause, raises it again one edge before the dwell would end, and then checks that the full dwell is counted again from the start.

// File: rtl/prot_sup_pkg.sv
// Shared encodings for the protection supervisor: states, fault codes
// ordered by priority (lower value wins), actions and severity classes.
package prot_sup_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_ALARM    = 3'd1,
        ST_DERATE   = 3'd2,
        ST_SHUTDOWN = 3'd3,
        ST_LATCH    = 3'd4,
        ST_RESET    = 3'd5
    } prot_state_e;

    typedef enum logic [3:0] {
        FC_NONE   = 4'd0,
        FC_SHORT  = 4'd1,
        FC_UVLO   = 4'd2,
        FC_OV3    = 4'd3,
        FC_OCUR   = 4'd4,
        FC_OTCRIT = 4'd5,
        FC_UVFAST = 4'd6,
        FC_OTWARN = 4'd7,
        FC_OV2    = 4'd8,
        FC_SENS   = 4'd9,
        FC_OV1    = 4'd10,
        FC_UVSLOW = 4'd11
    } fault_code_e;

    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_LOG      = 3'd1,
        ACT_DERATE   = 3'd2,
        ACT_SOFT_OFF = 3'd3,
        ACT_HARD_OFF = 3'd4,
        ACT_HOLD     = 3'd5,
        ACT_CHECK    = 3'd6,
        ACT_RESUME   = 3'd7
    } action_e;

    typedef enum logic [1:0] {
        CL_NONE   = 2'd0,
        CL_ALARM  = 2'd1,
        CL_DERATE = 2'd2,
        CL_TRIP   = 2'd3
    } fault_class_e;

    localparam int NUM_CODES = 12;

    // Maps a fault code onto its severity class.
    function automatic fault_class_e class_of(input fault_code_e c);
        case (c)
            FC_SHORT, FC_UVLO, FC_OV3,
            FC_OCUR, FC_OTCRIT, FC_UVFAST: return CL_TRIP;
            FC_OTWARN, FC_OV2, FC_SENS:    return CL_DERATE;
            FC_OV1, FC_UVSLOW:             return CL_ALARM;
            default:                       return CL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/prot_fault_arbiter.sv
// Combinational fault arbiter. Turns the raw qualified flags into one
// request bit per fault code, then picks the lowest active code as the
// winner and reports its severity class.
// Assumes: all flags are already synchronous and filtered upstream.
module prot_fault_arbiter
    import prot_sup_pkg::*;
(
    input  logic         short_i,
    input  logic         uvlo_i,
    input  logic         ocur_i,
    input  logic [2:0]   ov_i,
    input  logic         uv_low_i,
    input  logic         uv_fast_i,
    input  logic         ot_warn_i,
    input  logic         ot_crit_i,
    input  logic         sens_i,
    output fault_code_e  top_o,
    output fault_class_e cls_o
);

    logic [NUM_CODES-1:0] req;

    // Place each flag at the bit index equal to its fault code.
    always_comb begin
        req            = '0;
        req[FC_SHORT]  = short_i;
        req[FC_UVLO]   = uvlo_i;
        req[FC_OV3]    = ov_i[2];
        req[FC_OCUR]   = ocur_i;
        req[FC_OTCRIT] = ot_crit_i;
        req[FC_UVFAST] = uv_low_i & uv_fast_i;
        req[FC_OTWARN] = ot_warn_i;
        req[FC_OV2]    = ov_i[1];
        req[FC_SENS]   = sens_i;
        req[FC_OV1]    = ov_i[0];
        req[FC_UVSLOW] = uv_low_i & ~uv_fast_i;
    end

    // Scan from the lowest priority upward so the lowest index wins.
    always_comb begin
        top_o = FC_NONE;
        for (int i = NUM_CODES - 1; i >= 1; i--) begin
            if (req[i]) top_o = fault_code_e'(i[3:0]);
        end
    end

    assign cls_o = class_of(top_o);

endmodule

// File: rtl/prot_dwell_timer.sv
// Minimum-dwell timer for the derate state. Counts clock edges since the
// last restart and saturates at DWELL_CYCLES, where done_o rises.
// Assumes: DWELL_CYCLES >= 1.
module prot_dwell_timer #(
    parameter  int DWELL_CYCLES = 1000,
    localparam int DW_W         = $clog2(DWELL_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic done_o
);

    logic [DW_W-1:0] cnt_q;

    assign done_o = (cnt_q == DW_W'(DWELL_CYCLES));

    // Clear on restart, otherwise count up until the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (restart_i) cnt_q <= '0;
        else if (!done_o)   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/prot_repeat_ctr.sv
// Saturating shutdown repeat counter. Increments on each shutdown entry,
// stops at LIMIT and clears on request; at_limit_o flags the ceiling.
// Assumes: inc_i and clr_i are never both high (clear wins anyway).
module prot_repeat_ctr #(
    parameter  int LIMIT = 3,
    localparam int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o,
    output logic          at_limit_o
);

    logic [CW-1:0] cnt_q;

    assign at_limit_o = (cnt_q == CW'(LIMIT));
    assign cnt_o      = cnt_q;

    // Clear first, then increment below the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (clr_i)                cnt_q <= '0;
        else if (inc_i && !at_limit_o) cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/prot_supervisor.sv
// Graded protection supervisor top. Combines the arbitrated fault code
// with the state machine NORMAL/ALARM/DERATE/SHUTDOWN/LATCH/RESET, the
// derate dwell timer and the repeat counter. On every state change it
// registers the previous state, the fault code and the action, and
// pulses evt_o for one cycle.
// Assumes: fault flags are qualified and synchronous to clk.
module prot_supervisor
    import prot_sup_pkg::*;
#(
    parameter  int RETRY_LIMIT  = 3,
    parameter  int DWELL_CYCLES = 1000,
    localparam int CNT_W        = $clog2(RETRY_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flt_short,
    input  logic             flt_uvlo,
    input  logic             flt_ocur,
    input  logic [2:0]       ov_lvl,
    input  logic             uv_low,
    input  logic             uv_fast,
    input  logic             ot_warn,
    input  logic             ot_crit,
    input  logic             sens_bad,
    input  logic             clr_manual,
    output logic [2:0]       state_o,
    output logic [2:0]       prev_state_o,
    output logic [3:0]       fault_code_o,
    output logic [2:0]       action_o,
    output logic             evt_o,
    output logic             derate_o,
    output logic             shutdown_o,
    output logic [CNT_W-1:0] repeat_cnt_o
);

    fault_code_e  top_code;
    fault_class_e top_cls;
    prot_state_e  st_q, st_d, prev_q;
    fault_code_e  code_q;
    action_e      act_q, act_d;
    logic         evt_q;
    logic         dwell_done, at_limit, dwell_restart;
    logic         enter_sd, latch_clear;
    logic         quiet, trip_cause, derate_cause;

    prot_fault_arbiter u_arb (
        .short_i   (flt_short),
        .uvlo_i    (flt_uvlo),
        .ocur_i    (flt_ocur),
        .ov_i      (ov_lvl),
        .uv_low_i  (uv_low),
        .uv_fast_i (uv_fast),
        .ot_warn_i (ot_warn),
        .ot_crit_i (ot_crit),
        .sens_i    (sens_bad),
        .top_o     (top_code),
        .cls_o     (top_cls)
    );

    assign quiet        = (top_code == FC_NONE);
    assign trip_cause   = (top_cls == CL_TRIP);
    assign derate_cause = (top_cls == CL_DERATE);
    assign enter_sd     = (st_d == ST_SHUTDOWN) && (st_q != ST_SHUTDOWN);
    assign latch_clear  = (st_q == ST_LATCH) && (st_d == ST_RESET);
    assign dwell_restart = (st_q != ST_DERATE) || derate_cause;

    prot_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (dwell_restart),
        .done_o    (dwell_done)
    );

    prot_repeat_ctr #(.LIMIT(RETRY_LIMIT)) u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (enter_sd),
        .clr_i      (latch_clear),
        .cnt_o      (repeat_cnt_o),
        .at_limit_o (at_limit)
    );

    // Next-state decision by current state and the winning fault class.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_NORMAL, ST_ALARM: begin
                if (trip_cause)              st_d = ST_SHUTDOWN;
                else if (derate_cause)       st_d = ST_DERATE;
                else if (top_cls == CL_ALARM) st_d = ST_ALARM;
                else                         st_d = ST_NORMAL;
            end
            ST_DERATE: begin
                if (trip_cause)              st_d = ST_SHUTDOWN;
                else if (!derate_cause && dwell_done)
                    st_d = (top_cls == CL_ALARM) ? ST_ALARM : ST_NORMAL;
            end
            ST_SHUTDOWN: begin
                if (code_q == FC_SHORT || at_limit) st_d = ST_LATCH;
                else if (!trip_cause)               st_d = ST_RESET;
            end
            ST_LATCH: begin
                if (clr_manual && quiet)     st_d = ST_RESET;
            end
            ST_RESET: begin
                if (trip_cause)              st_d = ST_SHUTDOWN;
                else if (quiet)              st_d = ST_NORMAL;
            end
            default:                         st_d = ST_NORMAL;
        endcase
    end

    // Action code that accompanies the state being entered.
    always_comb begin
        case (st_d)
            ST_ALARM:    act_d = ACT_LOG;
            ST_DERATE:   act_d = ACT_DERATE;
            ST_SHUTDOWN: act_d = (top_code == FC_UVLO) ? ACT_HARD_OFF : ACT_SOFT_OFF;
            ST_LATCH:    act_d = ACT_HOLD;
            ST_RESET:    act_d = ACT_CHECK;
            default:     act_d = ACT_RESUME;
        endcase
    end

    // State register plus the event record captured at each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_NORMAL;
            prev_q <= ST_NORMAL;
            code_q <= FC_NONE;
            act_q  <= ACT_NONE;
            evt_q  <= 1'b0;
        end else begin
            st_q  <= st_d;
            evt_q <= (st_d != st_q);
            if (st_d != st_q) begin
                prev_q <= st_q;
                act_q  <= act_d;
                if (st_d != ST_LATCH) code_q <= top_code;
            end
        end
    end

    assign state_o      = st_q;
    assign prev_state_o = prev_q;
    assign fault_code_o = code_q;
    assign action_o     = act_q;
    assign evt_o        = evt_q;
    assign derate_o     = (st_q == ST_DERATE);
    assign shutdown_o   = (st_q == ST_SHUTDOWN) || (st_q == ST_LATCH) ||
                          (st_q == ST_RESET);

endmodule

// File: rtl/prot_supervisor_chk.sv
// Property checker for the protection supervisor, bound to every instance
// of the top. Watches the ports only, plus two small local counters.
module prot_supervisor_chk
    import prot_sup_pkg::*;
#(
    parameter  int RETRY_LIMIT  = 3,
    parameter  int DWELL_CYCLES = 1000,
    localparam int CNT_W        = $clog2(RETRY_LIMIT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flt_short,
    input logic             clr_manual,
    input logic [2:0]       state_o,
    input logic [2:0]       prev_state_o,
    input logic [3:0]       fault_code_o,
    input logic             evt_o,
    input logic             shutdown_o,
    input logic [CNT_W-1:0] repeat_cnt_o
);

    logic past_ok;
    int   der_run;

    // Marks that at least one cycle out of reset has been sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Counts consecutive cycles spent in DERATE (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)                      der_run <= 0;
        else if (state_o != ST_DERATE)   der_run <= 0;
        else if (der_run <= DWELL_CYCLES) der_run <= der_run + 1;
    end

    a_r1_reset_normal: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_o == ST_NORMAL && !shutdown_o));

    a_r2_short_trips: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_short && (state_o == ST_NORMAL || state_o == ST_ALARM ||
                       state_o == ST_DERATE))
        |=> state_o == ST_SHUTDOWN);

    a_r5_dwell_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(state_o) == ST_DERATE &&
         (state_o == ST_NORMAL || state_o == ST_ALARM))
        |-> der_run >= DWELL_CYCLES);

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(repeat_cnt_o) <= RETRY_LIMIT);

    a_r9_count_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state_o == ST_SHUTDOWN && $past(state_o) != ST_SHUTDOWN &&
         int'($past(repeat_cnt_o)) < RETRY_LIMIT)
        |-> int'(repeat_cnt_o) == int'($past(repeat_cnt_o)) + 1);

    a_r10_short_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_SHUTDOWN && fault_code_o == FC_SHORT)
        |=> state_o == ST_LATCH);

    a_r11_latch_off: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == ST_LATCH |=> shutdown_o);

    a_r11_latch_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_LATCH && !clr_manual) |=> state_o == ST_LATCH);

    a_r13_event_record: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && state_o != $past(state_o))
        |-> (evt_o && prev_state_o == $past(state_o)));

endmodule

bind prot_supervisor prot_supervisor_chk #(
    .RETRY_LIMIT  (RETRY_LIMIT),
    .DWELL_CYCLES (DWELL_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flt_short    (flt_short),
    .clr_manual   (clr_manual),
    .state_o      (state_o),
    .prev_state_o (prev_state_o),
    .fault_code_o (fault_code_o),
    .evt_o        (evt_o),
    .shutdown_o   (shutdown_o),
    .repeat_cnt_o (repeat_cnt_o)
);

// File: tb/prot_supervisor_bench.sv
`timescale 1ns/1ps
// Directed bench for the protection supervisor: one task per scenario.
module prot_supervisor_bench;

    localparam int RL = 3;
    localparam int DW = 6;
    localparam int CW = $clog2(RL + 1);

    localparam int S_NOR = 0, S_ALM = 1, S_DER = 2, S_SD = 3, S_LAT = 4, S_RST = 5;
    localparam int A_NONE = 0, A_LOG = 1, A_DER = 2, A_SOFT = 3, A_HARD = 4,
                   A_HOLD = 5, A_CHK = 6, A_RES = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flt_short, flt_uvlo, flt_ocur, uv_low, uv_fast, ot_warn, ot_crit;
    logic sens_bad, clr_manual;
    logic [2:0] ov_lvl;
    logic [2:0] state_o, prev_state_o, action_o;
    logic [3:0] fault_code_o;
    logic evt_o, derate_o, shutdown_o;
    logic [CW-1:0] repeat_cnt_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    prot_supervisor #(.RETRY_LIMIT(RL), .DWELL_CYCLES(DW)) u_prot_supervisor (
        .clk, .rst_n, .flt_short, .flt_uvlo, .flt_ocur, .ov_lvl, .uv_low,
        .uv_fast, .ot_warn, .ot_crit, .sens_bad, .clr_manual, .state_o,
        .prev_state_o, .fault_code_o, .action_o, .evt_o, .derate_o,
        .shutdown_o, .repeat_cnt_o
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_ev(input string req, input int st, input int code,
                             input int act, input int evt);
        chk(req, "state", int'(state_o), st);
        chk(req, "code", int'(fault_code_o), code);
        chk(req, "action", int'(action_o), act);
        chk(req, "evt", int'(evt_o), evt);
    endtask

    task automatic quiet_inputs();
        flt_short = 0; flt_uvlo = 0; flt_ocur = 0; ov_lvl = 3'b000;
        uv_low = 0; uv_fast = 0; ot_warn = 0; ot_crit = 0;
        sens_bad = 0; clr_manual = 0;
    endtask

    task automatic do_reset();
        quiet_inputs();
        rst_n = 0;
        step(2);
        rst_n = 1;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        expect_ev("R1", S_NOR, 0, A_NONE, 0);
        chk("R1", "prev", int'(prev_state_o), S_NOR);
        chk("R1", "shutdown", int'(shutdown_o), 0);
        chk("R1", "derate", int'(derate_o), 0);
        chk("R1", "repeat", int'(repeat_cnt_o), 0);
        clr_manual = 1; step();
        expect_ev("R11 clear ignored in NORMAL", S_NOR, 0, A_NONE, 0);
        clr_manual = 0;
    endtask

    task automatic t_ov_grading();
        do_reset();
        ov_lvl = 3'b001; step();
        expect_ev("R3 level1", S_ALM, 10, A_LOG, 1);
        chk("R13", "prev", int'(prev_state_o), S_NOR);
        step();
        chk("R13", "evt single cycle", int'(evt_o), 0);
        ov_lvl = 3'b011; step();
        expect_ev("R3 level2", S_DER, 8, A_DER, 1);
        chk("R2", "derate_o", int'(derate_o), 1);
        ov_lvl = 3'b111; step();
        expect_ev("R3 level3", S_SD, 3, A_SOFT, 1);
        chk("R13", "prev", int'(prev_state_o), S_DER);
        chk("R9", "repeat", int'(repeat_cnt_o), 1);
        ov_lvl = 3'b000; step();
        expect_ev("R10 retry", S_RST, 0, A_CHK, 1);
        chk("R2", "shutdown in RESET", int'(shutdown_o), 1);
        step();
        expect_ev("R12 resume", S_NOR, 0, A_RES, 1);
        chk("R2", "shutdown released", int'(shutdown_o), 0);
    endtask

    task automatic t_short_latch();
        do_reset();
        ov_lvl = 3'b010; step();
        expect_ev("R3", S_DER, 8, A_DER, 1);
        flt_short = 1; ov_lvl = 3'b000; step();
        expect_ev("R2 short from derate", S_SD, 1, A_SOFT, 1);
        step();
        expect_ev("R10 short latches", S_LAT, 1, A_HOLD, 1);
        flt_short = 0; step(3);
        expect_ev("R11 hold without clear", S_LAT, 1, A_HOLD, 0);
        chk("R11", "shutdown", int'(shutdown_o), 1);
        ov_lvl = 3'b001; clr_manual = 1; step();
        expect_ev("R11 clear with fault active", S_LAT, 1, A_HOLD, 0);
        ov_lvl = 3'b000; step();
        expect_ev("R11 clear", S_RST, 0, A_CHK, 1);
        chk("R9", "repeat cleared", int'(repeat_cnt_o), 0);
        clr_manual = 0; step();
        expect_ev("R12", S_NOR, 0, A_RES, 1);
    endtask

    task automatic t_uvlo_hard();
        do_reset();
        flt_uvlo = 1; ov_lvl = 3'b111; flt_ocur = 1; step();
        expect_ev("R8 uvlo hard-off", S_SD, 2, A_HARD, 1);
        quiet_inputs(); step();
        expect_ev("R10 uvlo retry", S_RST, 0, A_CHK, 1);
        step();
        chk("R12", "state", int'(state_o), S_NOR);
    endtask

    task automatic t_priority();
        do_reset();
        ov_lvl = 3'b111; flt_ocur = 1; ot_crit = 1; step();
        chk("R4 ov3 over ocur", "code", int'(fault_code_o), 3);
        do_reset();
        flt_ocur = 1; ot_crit = 1; sens_bad = 1; uv_low = 1; uv_fast = 1; step();
        chk("R4 ocur over otcrit", "code", int'(fault_code_o), 4);
        do_reset();
        ot_crit = 1; uv_low = 1; uv_fast = 1; ot_warn = 1; step();
        chk("R4 otcrit over uvfast", "code", int'(fault_code_o), 5);
        do_reset();
        ot_warn = 1; ov_lvl = 3'b011; sens_bad = 1; step();
        expect_ev("R4 otwarn over ov2", S_DER, 7, A_DER, 1);
        do_reset();
        ov_lvl = 3'b001; uv_low = 1; step();
        expect_ev("R4 ov1 over uvslow", S_ALM, 10, A_LOG, 1);
        do_reset();
        flt_short = 1; flt_uvlo = 1; flt_ocur = 1; ov_lvl = 3'b111; ot_crit = 1;
        step();
        expect_ev("R4 short wins", S_SD, 1, A_SOFT, 1);
    endtask

    task automatic t_retry_limit();
        do_reset();
        for (int i = 1; i <= RL; i++) begin
            ot_crit = 1; step();
            expect_ev("R9 trip", S_SD, 5, A_SOFT, 1);
            chk("R9", "repeat", int'(repeat_cnt_o), i);
            ot_crit = 0; step();
            if (i < RL) begin
                expect_ev("R10 retry below limit", S_RST, 0, A_CHK, 1);
                step();
                chk("R12", "state", int'(state_o), S_NOR);
            end else begin
                expect_ev("R10 latch at limit", S_LAT, 5, A_HOLD, 1);
            end
        end
        step(2);
        chk("R9", "saturated", int'(repeat_cnt_o), RL);
    endtask

    task automatic t_shutdown_hold();
        do_reset();
        flt_ocur = 1; step();
        expect_ev("R2 overcurrent", S_SD, 4, A_SOFT, 1);
        step(2);
        expect_ev("R10 stay while cause", S_SD, 4, A_SOFT, 0);
        flt_ocur = 0; step();
        chk("R10", "state", int'(state_o), S_RST);
        ot_warn = 1; step();
        expect_ev("R12 wait in RESET", S_RST, 0, A_CHK, 0);
        flt_ocur = 1; step();
        expect_ev("R12 retrip", S_SD, 4, A_SOFT, 1);
        chk("R12", "prev", int'(prev_state_o), S_RST);
        chk("R9", "repeat", int'(repeat_cnt_o), 2);
        quiet_inputs(); step(2);
        chk("R12", "state", int'(state_o), S_NOR);
    endtask

    task automatic t_dwell();
        do_reset();
        ot_warn = 1; step();
        expect_ev("R5 enter", S_DER, 7, A_DER, 1);
        step(3);
        ot_warn = 0; step(DW);
        chk("R5 dwell not over", "state", int'(state_o), S_DER);
        step();
        expect_ev("R5 exit normal", S_NOR, 0, A_RES, 1);
        chk("R5", "prev", int'(prev_state_o), S_DER);
        ot_warn = 1; step();
        ot_warn = 0; step(DW - 1);
        ot_warn = 1; step();
        ot_warn = 0; ov_lvl = 3'b001; step(DW);
        chk("R5 restart", "state", int'(state_o), S_DER);
        step();
        expect_ev("R5 exit alarm", S_ALM, 10, A_LOG, 1);
        ov_lvl = 3'b000; ot_warn = 1; step();
        ot_crit = 1; step();
        expect_ev("R5 escalate", S_SD, 5, A_SOFT, 1);
    endtask

    task automatic t_sensor();
        do_reset();
        sens_bad = 1; step();
        expect_ev("R6 sensor", S_DER, 9, A_DER, 1);
        step(4);
        chk("R6", "state", int'(state_o), S_DER);
        chk("R6", "shutdown", int'(shutdown_o), 0);
    endtask

    task automatic t_uv();
        do_reset();
        uv_fast = 1; step();
        expect_ev("R7 fast alone ignored", S_NOR, 0, A_NONE, 0);
        uv_fast = 0; uv_low = 1; step();
        expect_ev("R7 slow", S_ALM, 11, A_LOG, 1);
        uv_fast = 1; step();
        expect_ev("R7 fast", S_SD, 6, A_SOFT, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        quiet_inputs();
        t_reset();
        t_ov_grading();
        t_short_latch();
        t_uvlo_hard();
        t_priority();
        t_retry_limit();
        t_shutdown_hold();
        t_dwell();
        t_sensor();
        t_uv();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule